// File: doc/BRIEF.md
# Quadrature Direction Pulse Generator

This block turns the two phase signals of an incremental encoder into a clockwise pulse stream and a counter-clockwise pulse stream, then keeps a signed position count from them. No quadrature state machine is used. Four identical programmable cells each look up a 16-entry truth table and pass the result through a rise/fall delay filter counted in core clocks. Two cells are programmed as filtered followers of phase A and phase B. Their outputs are the delayed copies of the phases. The other two cells compare the live phases against those copies. While an edge has not yet reached the delayed copy, the mismatch is decoded into exactly one pulse, on the output that matches the direction of rotation.

Each direction pulse feeds an edge counter that starts at 1, wraps back to 1 at a configurable maximum, and counts its wraps in a separate overflow register. The position output is the clockwise running total minus the counter-clockwise running total. Cell tables, filter lengths and the counter maximum are static inputs, changed only while reset is held.

Top module: `quad_dir_pulse`

## Requirements
- R1: Phase A and phase B pass through a two-flop synchronizer before any cell sees them. With the default configuration, a phase edge driven just after a rising clock edge shows up on a direction pulse 4 rising edges later.
- R2: Each cell's raw result is bit `idx` of its 16-bit table, with idx = {cell1 out, cell0 out, B, A} and A as bit 0. The tables come in as one 64-bit word: bits 15:0 are cell 0 and bits 63:48 are cell 3. Cell 2 drives the clockwise output and cell 3 drives the counter-clockwise output.
- R3: A cell output goes from 0 to 1 only after the raw result has been 1 on `rise` consecutive rising clock edges. A rise length of 0 behaves as 1. A shorter glitch leaves the output unchanged.
- R4: A cell output goes from 1 to 0 only after the raw result has been 0 on `fall` consecutive rising clock edges. With the default lengths of 5 for the follower cells and 2 for the direction cells, each pulse is 5 cycles wide. Raising the clockwise fall length to 4 widens it to 7.
- R5: With tables 0xAAAA, 0xCCCC, 0x4182 and 0x2814, every valid edge of either phase gives exactly one pulse. The pulse is clockwise when A leads B (sequence 00, 10, 11, 01 for AB) and counter-clockwise when B leads.
- R6: When both phases change in the same cycle, neither direction output pulses and the position does not move.
- R7: Each edge counter advances on the rising edges of its pulse only. It resets to 1 and wraps from the maximum back to 1, and each wrap adds one to its overflow count. The position therefore stays exact for any maximum of 1 or more.
- R8: The position equals (clockwise count + max × clockwise overflows) − (counter-clockwise count + max × counter-clockwise overflows). It changes one cycle after a pulse rises.
- R9: While rst_ni is low, both pulses are 0 and the position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_a_i | input | 1 | Encoder phase A, asynchronous |
| enc_b_i | input | 1 | Encoder phase B, asynchronous |
| lut_cfg_i | input | 64 | Four 16-bit truth tables, cell 0 in bits 15:0 |
| rise_cfg_i | input | 4×FILT_W (16) | Rise filter lengths, cell 0 in the lowest field |
| fall_cfg_i | input | 4×FILT_W (16) | Fall filter lengths, cell 0 in the lowest field |
| cnt_max_i | input | CNT_W (16) | Edge counter wrap value |
| cw_o | output | 1 | Clockwise pulse |
| ccw_o | output | 1 | Counter-clockwise pulse |
| pos_o | output | CNT_W+OVF_W+1 (32) | Signed position |

## Verification
A phase edge reaches a direction pulse after two synchronizer edges plus the rise length of the direction cell. The pulse then stays high for the follower's delay length, adjusted by the difference between the fall and rise lengths of the direction cell. The position moves on the edge after the pulse rises. The reference model advances on every rising edge from the same rules. Both outputs and the position are compared with it on each falling edge, so every result is checked in the cycle it becomes due. Directed checks also count falling edges from the stimulus to measure pulse latency and width, and they confirm that the position is unchanged after glitches and simultaneous phase toggles.

// File: rtl/qdp_pkg.sv
package qdp_pkg;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned TBL_W   = 1 << SEL_W;
  localparam int unsigned N_CELL  = 4;
  localparam int unsigned N_DIR   = 2;
  localparam int unsigned FOL_A   = 0;
  localparam int unsigned FOL_B   = 1;
  localparam int unsigned DIR_CW  = 2;
  localparam int unsigned DIR_CCW = 3;
endpackage

// File: rtl/qdp_sync.sv
module qdp_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/qdp_lut_cell.sv
module qdp_lut_cell
  import qdp_pkg::*;
#(
  parameter int unsigned FILT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TBL_W-1:0]  tbl_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [FILT_W-1:0] rise_i,
  input  logic [FILT_W-1:0] fall_i,
  output logic              out_o
);
  logic              raw, out_q, done;
  logic [FILT_W-1:0] run_q, len;
  logic [FILT_W:0]   run_nxt;

  assign raw     = tbl_i[sel_i];
  // length of the pending transition: rising if output is low
  assign len     = out_q ? fall_i : rise_i;
  assign run_nxt = {1'b0, run_q} + 1'b1;
  // zero length falls through as one cycle
  assign done    = run_nxt >= {1'b0, len};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      run_q <= '0;
    end else if (raw != out_q) begin
      if (done) begin
        out_q <= raw;
        run_q <= '0;
      end else begin
        run_q <= run_nxt[FILT_W-1:0];
      end
    end else begin
      run_q <= '0;
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/qdp_edge_ctr.sv
module qdp_edge_ctr #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned OVF_W = 15,
  localparam int unsigned TOT_W = CNT_W + OVF_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic [CNT_W-1:0] max_i,
  output logic [TOT_W-1:0] total_o
);
  logic             prev_q, rise;
  logic [CNT_W-1:0] cnt_q;
  logic [OVF_W-1:0] ovf_q;

  assign rise = pulse_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      cnt_q  <= CNT_W'(1);
      ovf_q  <= '0;
    end else begin
      prev_q <= pulse_i;
      if (rise) begin
        if (cnt_q >= max_i) begin
          cnt_q <= CNT_W'(1);
          ovf_q <= ovf_q + 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign total_o = TOT_W'(cnt_q) + TOT_W'(max_i) * TOT_W'(ovf_q);
endmodule

// File: rtl/quad_dir_pulse.sv
module quad_dir_pulse
  import qdp_pkg::*;
#(
  parameter int unsigned FILT_W = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned OVF_W  = 15
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          enc_a_i,
  input  logic                          enc_b_i,
  input  logic [N_CELL*TBL_W-1:0]       lut_cfg_i,
  input  logic [N_CELL*FILT_W-1:0]      rise_cfg_i,
  input  logic [N_CELL*FILT_W-1:0]      fall_cfg_i,
  input  logic [CNT_W-1:0]              cnt_max_i,
  output logic                          cw_o,
  output logic                          ccw_o,
  output logic signed [CNT_W+OVF_W:0]   pos_o
);
  localparam int unsigned TOT_W = CNT_W + OVF_W + 1;

  logic [1:0]        enc_s;
  logic [N_CELL-1:0] cell_q;
  logic [SEL_W-1:0]  sel;
  logic [TOT_W-1:0]  tot [N_DIR];

  qdp_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({enc_b_i, enc_a_i}),
    .q_o   (enc_s)
  );

  // follower outputs are fed back as the upper select bits
  assign sel = {cell_q[FOL_B], cell_q[FOL_A], enc_s[1], enc_s[0]};

  for (genvar g = 0; g < N_CELL; g++) begin : g_cell
    qdp_lut_cell #(.FILT_W(FILT_W)) u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tbl_i (lut_cfg_i[g*TBL_W +: TBL_W]),
      .sel_i (sel),
      .rise_i(rise_cfg_i[g*FILT_W +: FILT_W]),
      .fall_i(fall_cfg_i[g*FILT_W +: FILT_W]),
      .out_o (cell_q[g])
    );
  end

  for (genvar d = 0; d < N_DIR; d++) begin : g_ctr
    qdp_edge_ctr #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pulse_i(cell_q[DIR_CW + d]),
      .max_i  (cnt_max_i),
      .total_o(tot[d])
    );
  end

  assign cw_o  = cell_q[DIR_CW];
  assign ccw_o = cell_q[DIR_CCW];
  assign pos_o = $signed(tot[0] - tot[1]);
endmodule

// File: rtl/qdp_chk.sv
module qdp_chk #(
  parameter int unsigned PW = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cw_i,
  input logic                 ccw_i,
  input logic signed [PW-1:0] pos_i
);
  // R8
  cw_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cw_i) && !$rose(ccw_i)) |=> (pos_i == $past(pos_i) + 1));

  // R8
  ccw_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ccw_i) && !$rose(cw_i)) |=> (pos_i == $past(pos_i) - 1));

  // R7
  pos_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$rose(cw_i) && !$rose(ccw_i)) |=> $stable(pos_i));

  // R9
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      rst_state_chk: assert (!cw_i && !ccw_i && pos_i == '0);
    end
  end
endmodule

bind quad_dir_pulse qdp_chk #(.PW(CNT_W + OVF_W + 1)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cw_i  (cw_o),
  .ccw_i (ccw_o),
  .pos_i (pos_o)
);

// File: tb/tb_quad_dir_pulse.sv
`timescale 1ns/1ps
module tb_quad_dir_pulse;
  localparam int FW = 4;
  localparam logic [63:0] LUT_DEF  = {16'h2814, 16'h4182, 16'hCCCC, 16'hAAAA};
  localparam logic [15:0] LEN_DEF  = {4'd2, 4'd2, 4'd5, 4'd5};

  logic clk = 1'b0, rst_n = 1'b0, a = 1'b0, b = 1'b0;
  logic [63:0] lut  = LUT_DEF;
  logic [15:0] rise = LEN_DEF, fall = LEN_DEF, cmax = 16'hFFFF;
  logic cw, ccw;
  logic signed [31:0] pos;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  quad_dir_pulse dut (
    .clk_i(clk), .rst_ni(rst_n), .enc_a_i(a), .enc_b_i(b),
    .lut_cfg_i(lut), .rise_cfg_i(rise), .fall_cfg_i(fall), .cnt_max_i(cmax),
    .cw_o(cw), .ccw_o(ccw), .pos_o(pos)
  );

  // behavioural reference
  bit [1:0] m_s1, m_s2;
  bit [3:0] m_out;
  int m_run[4];
  bit m_pc, m_pcc;
  int m_cw, m_ccw;

  function automatic int flen(int i, bit up);
    int l;
    l = up ? int'(rise[i*FW +: FW]) : int'(fall[i*FW +: FW]);
    return (l < 1) ? 1 : l;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_out = 0; m_pc = 0; m_pcc = 0; m_cw = 0; m_ccw = 0;
      for (int i = 0; i < 4; i++) m_run[i] = 0;
    end else begin
      bit [3:0] nout;
      int nrun[4];
      int ix;
      ix = {28'd0, m_out[1], m_out[0], m_s2[1], m_s2[0]};
      for (int i = 0; i < 4; i++) begin
        bit r;
        r = lut[i*16 + ix];
        nout[i] = m_out[i];
        nrun[i] = 0;
        if (r != m_out[i]) begin
          if (m_run[i] + 1 >= flen(i, r)) nout[i] = r;
          else nrun[i] = m_run[i] + 1;
        end
      end
      if (m_out[2] && !m_pc) m_cw++;
      if (m_out[3] && !m_pcc) m_ccw++;
      m_pc = m_out[2];
      m_pcc = m_out[3];
      m_s2 = m_s1;
      m_s1 = {b, a};
      m_out = nout;
      m_run = nrun;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cw == m_out[2], "R5", "cw vs model", longint'(cw), longint'(m_out[2]));
      chk(ccw == m_out[3], "R5", "ccw vs model", longint'(ccw), longint'(m_out[3]));
      chk(pos == m_cw - m_ccw, "R8", "pos vs model", longint'(pos), longint'(m_cw - m_ccw));
    end
  end

  task automatic summary();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic do_reset(input logic [63:0] l, input logic [15:0] r,
                          input logic [15:0] f, input logic [15:0] m);
    @(negedge clk);
    rst_n = 0; a = 0; b = 0; lut = l; rise = r; fall = f; cmax = m;
    repeat (3) @(negedge clk);
    chk(!cw && !ccw && pos == 0, "R9", "reset state", longint'(pos), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic step(input bit na, input bit nb);
    @(negedge clk);
    a = na; b = nb;
    repeat (14) @(negedge clk);
  endtask

  task automatic cw_turn();
    step(1, 0); step(1, 1); step(0, 1); step(0, 0);
  endtask

  task automatic ccw_turn();
    step(0, 1); step(1, 1); step(1, 0); step(0, 0);
  endtask

  task automatic shape(output int lat, output int wid);
    @(negedge clk);
    a = 1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!cw && lat < 40);
    wid = 0;
    while (cw && wid < 40) begin @(negedge clk); wid++; end
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    summary();
  end

  initial begin
    int lat, wid;
    bit seen;
    do_reset(LUT_DEF, LEN_DEF, LEN_DEF, 16'hFFFF);
    shape(lat, wid);
    chk(lat == 4, "R1", "pulse latency", lat, 4);
    chk(wid == 5, "R4", "pulse width", wid, 5);
    chk(pos == 1, "R5", "one edge one pulse", longint'(pos), 1);
    step(1, 1); step(0, 1); step(0, 0);
    chk(pos == 4, "R5", "full cw turn", longint'(pos), 4);
    repeat (3) cw_turn();
    chk(pos == 16, "R5", "four cw turns", longint'(pos), 16);
    repeat (2) ccw_turn();
    chk(pos == 8, "R5", "two ccw turns back", longint'(pos), 8);

    // R6 simultaneous toggle
    do_reset(LUT_DEF, LEN_DEF, LEN_DEF, 16'hFFFF);
    @(negedge clk); a = 1; b = 1;
    seen = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); seen |= cw | ccw; end
    chk(!seen, "R6", "no pulse on dual toggle", longint'(seen), 0);
    chk(pos == 0, "R6", "pos after dual toggle", longint'(pos), 0);

    // R3 single-cycle glitch on A
    do_reset(LUT_DEF, LEN_DEF, LEN_DEF, 16'hFFFF);
    @(negedge clk); a = 1;
    @(negedge clk); a = 0;
    seen = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); seen |= cw | ccw; end
    chk(!seen && pos == 0, "R3", "glitch suppressed", longint'(pos), 0);
    step(1, 0);
    chk(pos == 1, "R3", "real edge after glitch", longint'(pos), 1);

    // R3 zero rise length acts as one
    do_reset(LUT_DEF, {4'd2, 4'd0, 4'd5, 4'd5}, LEN_DEF, 16'hFFFF);
    shape(lat, wid);
    chk(lat == 3, "R3", "zero rise latency", lat, 3);

    // R4 longer fall on cw cell
    do_reset(LUT_DEF, LEN_DEF, {4'd2, 4'd4, 4'd5, 4'd5}, 16'hFFFF);
    shape(lat, wid);
    chk(wid == 7, "R4", "fall 4 width", wid, 7);

    // R2 programmable table: cw cell forced to all ones
    do_reset({16'h2814, 16'hFFFF, 16'hCCCC, 16'hAAAA}, LEN_DEF, LEN_DEF, 16'hFFFF);
    repeat (10) @(negedge clk);
    chk(cw == 1, "R2", "all-ones table", longint'(cw), 1);
    chk(pos == 1, "R2", "single rise counted", longint'(pos), 1);

    // R7 small wrap value
    do_reset(LUT_DEF, LEN_DEF, LEN_DEF, 16'd3);
    repeat (3) cw_turn();
    chk(pos == 12, "R7", "wrap at 3 cw", longint'(pos), 12);
    repeat (2) ccw_turn();
    chk(pos == 4, "R7", "wrap at 3 ccw", longint'(pos), 4);
    repeat (3) ccw_turn();
    chk(pos == -8, "R7", "negative after wraps", longint'(pos), -8);

    summary();
  end
endmodule